// File: doc/BRIEF.md
# Ramped FSK Frequency Sweep Controller

This block generates a 48-bit frequency tuning word that walks in linear steps between two programmed end frequencies, F1 and F2. A programmable step period sets how many clock cycles each frequency value is held. A programmable delta word sets how far each step moves. In follow mode the FSK input selects the end frequency the word heads for: low selects F1 and high selects F2. If the input changes before the word arrives, the ramp turns around immediately.

In triangle mode the block ignores the FSK input and sweeps between the two ends continuously. The FSK level sampled on the rising edge of the triangle control chooses the end where the sweep starts. The end frequencies, delta and step period are first presented on shadow inputs. They are copied into the working set together on an update strobe, and this copy never restarts a ramp in progress. Loading new values mid-sweep therefore builds a piecewise sweep from several linear segments.

The tuning word is a level output that is always current. `word_valid` marks each cycle in which a new value has just been written to it. The consumer of the word, such as a phase accumulator, reads it on every cycle. For that reason the output has no ready signal and takes no back-pressure. A stall could only be expressed by lowering `enable`, which freezes the sweep.

Top module: `ramp_fsk_sweep`

## Requirements
- R1: A synchronous reset loads `word_out` with `f1_in`, loads the working set from the shadow inputs, clears the step timer and holds `word_valid` low.
- R2: While enabled, a step occurs once every RATE+1 clock cycles, where RATE is the working step period. A period of zero gives a step on every cycle.
- R3: In follow mode, with `fsk_in` low the word moves toward F1, and with `fsk_in` high it moves toward F2. Each step moves it by exactly the working delta.
- R4: If the distance to the target is not larger than the delta, the step lands exactly on the target. Later steps keep the word there until the target changes.
- R5: If `fsk_in` changes before the word reaches its target, the next step already moves toward the other end, with the same delta and rate.
- R6: On a rising edge of `tri_en` seen while enabled, the word is loaded with F2 when `fsk_in` is high and with F1 when it is low. `word_valid` pulses and the step timer restarts. A timer expiry in the same cycle does not add a step.
- R7: While `tri_en` stays high, `fsk_in` has no effect. The word sweeps from one end to the other and back, reversing on the step that reaches an end. Every value, including the end values, is held for one step period.
- R8: Shadow values reach the working set only on a cycle with `upd_strobe` high. The next step uses them without restarting the ramp or the timer.
- R9: A working delta of zero leaves the word unchanged on every step.
- R10: While `enable` is low, the word, the step timer and the triangle edge detector hold still, and `word_valid` stays low.
- R11: `word_valid` is high in the cycle after a step or a triangle start, and low in every other cycle. While it is low, `word_out` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control for the sweep |
| upd_strobe | input | 1 | Copies the shadow inputs into the working set |
| f1_in | input | 48 | Shadow value of the lower-select end frequency F1 |
| f2_in | input | 48 | Shadow value of the upper-select end frequency F2 |
| delta_in | input | 48 | Shadow value of the step size |
| rate_in | input | 20 | Shadow step period (period is value+1 cycles) |
| fsk_in | input | 1 | Target select in follow mode; start select at triangle entry |
| tri_en | input | 1 | Triangle sweep control |
| word_out | output | 48 | Current frequency tuning word |
| word_valid | output | 1 | Pulses when word_out has just been written |

## Verification
A rising edge of the triangle control can land on the same cycle as a timer expiry. In that case the start load must win: the word becomes exactly F1 or F2, with no delta added, and the timer starts again from zero. The bench forces this collision by setting a step period of zero, so that every cycle is an expiry, before raising the triangle control. It then checks that the first valid word is the bare end frequency and that the second word is exactly one delta away. A second overlap, an update strobe arriving mid-count, is judged by checking that the step after the strobe uses the new delta and that the timer keeps its current count.

// File: rtl/rfsk_pkg.sv
package rfsk_pkg;
  localparam int DEF_FTW_W  = 48;
  localparam int DEF_RATE_W = 20;

  typedef enum logic {
    TGT_F1 = 1'b0,
    TGT_F2 = 1'b1
  } tgt_sel_e;
endpackage

// File: rtl/rfsk_rate_timer.sv
module rfsk_rate_timer #(
  parameter int RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] period,
  output logic              tick
);
  logic [RATE_W-1:0] cnt;
  logic              expired;

  // ">=" lets a shorter period loaded mid-count expire at once
  assign expired = (cnt >= period);
  assign tick    = run && expired;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      if (expired) cnt <= '0;
      else         cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rfsk_step_unit.sv
module rfsk_step_unit #(
  parameter int FTW_W = 48
) (
  input  logic [FTW_W-1:0] cur,
  input  logic [FTW_W-1:0] tgt,
  input  logic [FTW_W-1:0] delta,
  output logic [FTW_W-1:0] nxt,
  output logic             arrive
);
  logic             going_up;
  logic [FTW_W-1:0] gap;

  always_comb begin
    going_up = (tgt > cur);
    gap      = going_up ? (tgt - cur) : (cur - tgt);
    if (gap <= delta) begin
      nxt    = tgt;
      arrive = 1'b1;
    end else begin
      nxt    = going_up ? (cur + delta) : (cur - delta);
      arrive = 1'b0;
    end
  end
endmodule

// File: rtl/ramp_fsk_sweep.sv
module ramp_fsk_sweep
  import rfsk_pkg::*;
#(
  parameter int FTW_W  = DEF_FTW_W,
  parameter int RATE_W = DEF_RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              upd_strobe,
  input  logic [FTW_W-1:0]  f1_in,
  input  logic [FTW_W-1:0]  f2_in,
  input  logic [FTW_W-1:0]  delta_in,
  input  logic [RATE_W-1:0] rate_in,
  input  logic              fsk_in,
  input  logic              tri_en,
  output logic [FTW_W-1:0]  word_out,
  output logic              word_valid
);
  // working set, loaded together so every bit of a word changes at once
  logic [FTW_W-1:0]  f1_a, f2_a, delta_a;
  logic [RATE_W-1:0] rate_a;

  always_ff @(posedge clk) begin
    if (rst || upd_strobe) begin
      f1_a    <= f1_in;
      f2_a    <= f2_in;
      delta_a <= delta_in;
      rate_a  <= rate_in;
    end
  end

  logic     tri_q;
  tgt_sel_e tri_tgt;
  logic     tri_rise, in_tri;
  tgt_sel_e cur_sel;
  logic [FTW_W-1:0] target, step_word;
  logic     arrive, timer_tick, step_go;

  assign tri_rise = enable && tri_en && !tri_q;
  assign in_tri   = tri_en && tri_q;
  assign cur_sel  = in_tri ? tri_tgt : (fsk_in ? TGT_F2 : TGT_F1);
  assign target   = (cur_sel == TGT_F2) ? f2_a : f1_a;
  assign step_go  = timer_tick && !tri_rise;

  rfsk_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (enable),
    .restart (tri_rise),
    .period  (rate_a),
    .tick    (timer_tick)
  );

  rfsk_step_unit #(.FTW_W(FTW_W)) u_step (
    .cur    (word_out),
    .tgt    (target),
    .delta  (delta_a),
    .nxt    (step_word),
    .arrive (arrive)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out   <= f1_in;
      word_valid <= 1'b0;
      tri_q      <= 1'b0;
      tri_tgt    <= TGT_F1;
    end else begin
      word_valid <= 1'b0;
      if (enable) begin
        tri_q <= tri_en;
        if (tri_rise) begin
          word_out   <= fsk_in ? f2_a : f1_a;
          tri_tgt    <= fsk_in ? TGT_F1 : TGT_F2;
          word_valid <= 1'b1;
        end else if (step_go) begin
          word_out   <= step_word;
          word_valid <= 1'b1;
          // turn around on the step that lands on an end
          if (in_tri && arrive)
            tri_tgt <= (tri_tgt == TGT_F2) ? TGT_F1 : TGT_F2;
        end
      end
    end
  end
endmodule

// File: rtl/ramp_fsk_sweep_chk.sv
module ramp_fsk_sweep_chk #(
  parameter int FTW_W  = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [FTW_W-1:0] f1_in,
  input logic [FTW_W-1:0] word_out,
  input logic             word_valid,
  input logic [FTW_W-1:0] delta_a,
  input logic             tri_rise
);
  logic [FTW_W-1:0] prev_word;
  logic [FTW_W-1:0] moved;
  always_ff @(posedge clk) prev_word <= word_out;
  assign moved = (word_out > prev_word) ? (word_out - prev_word)
                                        : (prev_word - word_out);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!word_valid && word_out == $past(f1_in)));

  p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !word_valid);

  p_step_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !$past(tri_rise) && !$past(rst)) |-> (moved <= $past(delta_a)));

  p_quiet_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (!word_valid && !$past(rst)) |-> $stable(word_out));
endmodule

bind ramp_fsk_sweep ramp_fsk_sweep_chk #(.FTW_W(FTW_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .f1_in      (f1_in),
  .word_out   (word_out),
  .word_valid (word_valid),
  .delta_a    (delta_a),
  .tri_rise   (tri_rise)
);

// File: tb/ramp_fsk_sweep_tb.sv
module ramp_fsk_sweep_tb;
  localparam int FW = 48;
  localparam int RW = 20;

  logic          clk = 1'b0;
  logic          rst, enable, upd_strobe, fsk_in, tri_en;
  logic [FW-1:0] f1_in, f2_in, delta_in;
  logic [RW-1:0] rate_in;
  logic [FW-1:0] word_out;
  logic          word_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ramp_fsk_sweep u_dut (
    .clk(clk), .rst(rst), .enable(enable), .upd_strobe(upd_strobe),
    .f1_in(f1_in), .f2_in(f2_in), .delta_in(delta_in), .rate_in(rate_in),
    .fsk_in(fsk_in), .tri_en(tri_en), .word_out(word_out), .word_valid(word_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!word_valid && gap < 500);
    if (!word_valid) check(1'b0, "timeout", gap, 0);
  endtask

  task automatic expect_step(input longint exp_w, input int exp_gap, input string req);
    int g;
    wait_valid(g);
    check(word_out == exp_w, req, word_out, exp_w);
    if (exp_gap > 0) check(g == exp_gap, {req, " gap"}, g, exp_gap);
  endtask

  task automatic load_cfg(input longint d, input int r);
    delta_in   = d;
    rate_in    = r;
    upd_strobe = 1'b1;
    @(negedge clk);
    upd_strobe = 1'b0;
  endtask

  task automatic t_reset;  // R1
    rst = 1'b1; enable = 1'b0; upd_strobe = 1'b0; fsk_in = 1'b0; tri_en = 1'b0;
    f1_in = 1000; f2_in = 1500; delta_in = 150; rate_in = 3;
    repeat (3) @(negedge clk);
    check(word_out == 1000, "R1 word", word_out, 1000);
    check(word_valid == 1'b0, "R1 valid", word_valid, 0);
    rst = 1'b0;
  endtask

  task automatic t_freeze;  // R10
    bit seen = 0;
    fsk_in = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (word_valid) seen = 1;
    end
    check(!seen, "R10 no valid", seen, 0);
    check(word_out == 1000, "R10 word held", word_out, 1000);
  endtask

  task automatic t_ramp_up;  // R2 R3 R4 R11
    enable = 1'b1;
    expect_step(1150, 4, "R3 up");
    @(negedge clk);
    check(!word_valid, "R11 single pulse", word_valid, 0);
    expect_step(1300, 3, "R2 step");
    expect_step(1450, 4, "R3 up");
    expect_step(1500, 4, "R4 clamp");
    expect_step(1500, 4, "R4 hold");
  endtask

  task automatic t_reverse;  // R5
    fsk_in = 1'b0;
    expect_step(1350, 0, "R3 down");
    expect_step(1200, 4, "R3 down");
    fsk_in = 1'b1;
    expect_step(1350, 4, "R5 reverse");
    expect_step(1500, 4, "R5 back");
  endtask

  task automatic t_update;  // R8 R2
    fsk_in   = 1'b0;
    delta_in = 100;  // no strobe: must be ignored
    expect_step(1350, 0, "R8 no strobe");
    load_cfg(100, 1);
    expect_step(1250, 0, "R8 new delta");
    expect_step(1150, 2, "R8 new rate");
    expect_step(1050, 2, "R2 rate1");
    expect_step(1000, 2, "R4 clamp low");
  endtask

  task automatic t_zero;  // R9 R2
    fsk_in = 1'b1;
    load_cfg(0, 0);
    for (int i = 0; i < 4; i++) expect_step(1000, (i == 0) ? 0 : 1, "R9 zero delta");
    load_cfg(100, 0);
    expect_step(1100, 0, "R2 rate0");
    expect_step(1200, 1, "R2 rate0");
    fsk_in = 1'b0;
    load_cfg(150, 3);
    for (int i = 0; i < 10 && word_out != 1000; i++) begin
      int g;
      wait_valid(g);
    end
    check(word_out == 1000, "R3 return F1", word_out, 1000);
  endtask

  task automatic t_triangle;  // R6 R7
    longint seq[9] = '{1350, 1200, 1050, 1000, 1150, 1300, 1450, 1500, 1350};
    fsk_in = 1'b1;
    tri_en = 1'b1;
    expect_step(1500, 1, "R6 start F2");
    for (int i = 0; i < 9; i++) begin
      fsk_in = i[0];
      expect_step(seq[i], 4, "R7 sweep");
    end
    tri_en = 1'b0;
    fsk_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_tri_collide;  // R6 with timer expiry in the same cycle
    load_cfg(150, 0);
    @(negedge clk);
    fsk_in = 1'b0;
    tri_en = 1'b1;
    expect_step(1000, 1, "R6 start F1");
    expect_step(1150, 1, "R7 toward F2");
    tri_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_freeze();
    t_ramp_up();
    t_reverse();
    t_update();
    t_zero();
    t_triangle();
    t_tri_collide();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule